// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns a three-wire serial audio stream (bit clock, word clock, serial data) into parallel 24-bit left and right samples. The system clock samples all three serial lines. Every rising bit-clock edge seen in that domain shifts one data bit in. The word clock marks the channel boundaries. Four framings are supported: I2S, left-justified, and right-justified at 16 or 24 bits.

A 4-bit mode word selects the framing. It also selects stereo or single-channel output, and it selects a bypass mode for an external interpolation filter. In bypass mode a word clock running at four or eight times the sample rate frames mono 24-bit words, and each falling edge of that clock closes one word. The block also reports two decoded flags: the filter-rolloff choice and whether bypass mode is active. Each delivered word raises a one-cycle strobe next to its data.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is held, and after reset until the first delivered word, both strobes are low and both data outputs are zero.
- R2: Mode field layout: mode[3] is mono, mode[2] is channel-select, and mode[1:0] is the framing code. The framing codes are 00 = I2S, 01 = left-justified, 10 = right-justified 16-bit and 11 = right-justified 24-bit. With mono=0, channel-select=1 and code 11 the block is in bypass mode, and `bypass_on` is 1.
- R3: `slow_rolloff` is 1 exactly when mono=0, channel-select=1 and bypass mode is not selected. Otherwise it is 0.
- R4: Left-justified: a high word clock marks the left channel. The MSB is the bit sampled at the first bit-clock rise after a word-clock change, and the next 23 bits follow it MSB first.
- R5: I2S: a low word clock marks the left channel. The MSB is sampled one bit clock after the word-clock change.
- R6: Right-justified: a high word clock marks the left channel. The LSB is the last bit sampled before the word-clock change. In 24-bit mode the last 24 bits form the word. In 16-bit mode the last 16 bits are sign-extended to 24.
- R7: Bit clocks beyond the word length are ignored: trailing bits in I2S and left-justified framing, leading bits in right-justified framing.
- R8: In stereo mode each word raises only its own channel's strobe, and the two strobes are never high together.
- R9: Mono mode (mono=1) delivers only the left-channel words (channel-select=0) or only the right-channel words (channel-select=1). Each delivered word is driven on both outputs with both strobes high.
- R10: Bypass mode: the 24 bits sampled before a falling word-clock edge form one word. The word is driven on both outputs with both strobes high.
- R11: A strobe lasts one system-clock cycle. It rises in the cycle after the system clock first sees the bit-clock rise that completes the word.
- R12: A channel period is delivered only if it began with a word-clock change seen after reset. The period that is already in progress when reset ends is never delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial lines |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 4 | {mono, channel-select, framing code[1:0]} |
| bclk | input | 1 | Serial bit clock |
| wclk | input | 1 | Word clock (channel / word framing) |
| sdata | input | 1 | Serial data, MSB first, two's complement |
| l_valid | output | 1 | One-cycle strobe for a new left word |
| l_data | output | 24 | Left sample |
| r_valid | output | 1 | One-cycle strobe for a new right word |
| r_data | output | 24 | Right sample |
| slow_rolloff | output | 1 | Decoded rolloff flag |
| bypass_on | output | 1 | Decoded bypass-mode flag |

## Verification
In the right-justified and bypass framings, one bit-clock rise does two jobs: it closes the previous word and it opens the framing of the next word. The bench provokes this with back-to-back channel periods that carry leading filler bits of all ones. Each strobe is then judged against a scoreboard word that must hold only the last bits before the edge, with no filler and no bit from the new period. In mono mode the unselected channel's completion falls on the same kind of edge. The bench checks that this completion raises nothing.

// File: rtl/sai_pkg.sv
package sai_pkg;

  typedef enum logic [1:0] {
    FMT_I2S  = 2'b00,
    FMT_LJ   = 2'b01,
    FMT_RJ16 = 2'b10,
    FMT_RJ24 = 2'b11
  } fmt_e;

  typedef struct packed {
    logic mono;
    logic chsel;
    fmt_e fmt;
  } mode_t;

  function automatic logic is_bypass(mode_t m);
    return !m.mono && m.chsel && (m.fmt == FMT_RJ24);
  endfunction

  function automatic logic is_slow(mode_t m);
    return !m.mono && m.chsel && !is_bypass(m);
  endfunction

  // word-clock level that marks the left channel
  function automatic logic left_level(fmt_e f);
    return f != FMT_I2S;
  endfunction

endpackage

// File: rtl/sai_bitstage.sv
module sai_bitstage #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bclk,
  input  logic         wclk,
  input  logic         sdata,
  output logic         rise,
  output logic         wedge,
  output logic         wl_prev,
  output logic         wl_now,
  output logic [W-1:0] sh_prev,
  output logic [W-1:0] sh_now
);
  logic bclk_q, have_last;

  assign rise    = bclk && !bclk_q;
  assign wl_now  = wclk;
  assign wedge   = rise && have_last && (wclk != wl_prev);
  assign sh_now  = {sh_prev[W-2:0], sdata};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_q    <= 1'b0;
      have_last <= 1'b0;
      wl_prev   <= 1'b0;
      sh_prev   <= '0;
    end else begin
      bclk_q <= bclk;
      if (rise) begin
        have_last <= 1'b1;
        wl_prev   <= wclk;
        sh_prev   <= sh_now;
      end
    end
  end
endmodule

// File: rtl/sai_framer.sv
module sai_framer
  import sai_pkg::*;
#(
  parameter int W  = 24,
  parameter int SW = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  mode_t        mode,
  input  logic         rise,
  input  logic         wedge,
  input  logic         wl_prev,
  input  logic         wl_now,
  input  logic [W-1:0] sh_prev,
  input  logic [W-1:0] sh_now,
  output logic         done,
  output logic         done_left,
  output logic [W-1:0] word
);
  localparam int CW = $clog2(W + 2);
  localparam logic [CW-1:0] CMAX = CW'(W + 1);

  logic [CW-1:0] cnt, idx;
  logic          framed, framed_now, lvl;

  assign idx        = wedge ? '0 : cnt;
  assign framed_now = framed || wedge;

  always_comb begin
    done = 1'b0;
    word = sh_prev;
    lvl  = wl_prev;
    if (is_bypass(mode)) begin
      done = wedge && framed && wl_prev;
    end else begin
      unique case (mode.fmt)
        FMT_LJ: begin
          done = rise && framed_now && (idx == CW'(W - 1));
          word = sh_now;
          lvl  = wl_now;
        end
        FMT_I2S: begin
          done = rise && framed_now && (idx == CW'(W));
          word = sh_now;
          lvl  = wl_now;
        end
        FMT_RJ16: begin
          done = wedge && framed;
          word = {{(W-SW){sh_prev[SW-1]}}, sh_prev[SW-1:0]};
        end
        default: done = wedge && framed;
      endcase
    end
    done_left = is_bypass(mode) || (lvl == left_level(mode.fmt));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      framed <= 1'b0;
    end else if (rise) begin
      framed <= framed_now;
      cnt    <= (idx == CMAX) ? CMAX : idx + 1'b1;
    end
  end
endmodule

// File: rtl/sai_router.sv
module sai_router
  import sai_pkg::*;
#(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  mode_t        mode,
  input  logic         done,
  input  logic         done_left,
  input  logic [W-1:0] word,
  output logic         l_valid,
  output logic [W-1:0] l_data,
  output logic         r_valid,
  output logic [W-1:0] r_data
);
  logic to_l, to_r;

  always_comb begin
    if (is_bypass(mode)) begin
      to_l = done;
      to_r = done;
    end else if (mode.mono) begin
      to_l = done && (done_left != mode.chsel);
      to_r = to_l;
    end else begin
      to_l = done && done_left;
      to_r = done && !done_left;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l_valid <= 1'b0;
      r_valid <= 1'b0;
      l_data  <= '0;
      r_data  <= '0;
    end else begin
      l_valid <= to_l;
      r_valid <= to_r;
      if (to_l) l_data <= word;
      if (to_r) r_data <= word;
    end
  end
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import sai_pkg::*;
#(
  parameter int W  = 24,
  parameter int SW = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   mode,
  input  logic         bclk,
  input  logic         wclk,
  input  logic         sdata,
  output logic         l_valid,
  output logic [W-1:0] l_data,
  output logic         r_valid,
  output logic [W-1:0] r_data,
  output logic         slow_rolloff,
  output logic         bypass_on
);
  mode_t        m;
  logic         bit_rise, wedge, wl_prev, wl_now, word_done, done_left;
  logic [W-1:0] sh_prev, sh_now, word;

  assign m            = mode_t'(mode);
  assign slow_rolloff = is_slow(m);
  assign bypass_on    = is_bypass(m);

  sai_bitstage #(.W(W)) u_bits (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .wclk(wclk), .sdata(sdata),
    .rise(bit_rise), .wedge(wedge), .wl_prev(wl_prev), .wl_now(wl_now),
    .sh_prev(sh_prev), .sh_now(sh_now)
  );

  sai_framer #(.W(W), .SW(SW)) u_frame (
    .clk(clk), .rst_n(rst_n), .mode(m), .rise(bit_rise), .wedge(wedge),
    .wl_prev(wl_prev), .wl_now(wl_now), .sh_prev(sh_prev), .sh_now(sh_now),
    .done(word_done), .done_left(done_left), .word(word)
  );

  sai_router #(.W(W)) u_route (
    .clk(clk), .rst_n(rst_n), .mode(m), .done(word_done),
    .done_left(done_left), .word(word),
    .l_valid(l_valid), .l_data(l_data), .r_valid(r_valid), .r_data(r_data)
  );
endmodule

// File: rtl/sai_checker.sv
module sai_checker #(
  parameter int W  = 24,
  parameter int SW = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [3:0]   mode,
  input logic         bit_rise,
  input logic         word_done,
  input logic         l_valid,
  input logic [W-1:0] l_data,
  input logic         r_valid,
  input logic [W-1:0] r_data,
  input logic         bypass_on
);
  // R8: stereo strobes never coincide
  p_stereo_apart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode[3] && !bypass_on) |-> !(l_valid && r_valid));

  // R9, R10: paired delivery in mono and bypass modes
  p_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode[3] || bypass_on) && (l_valid || r_valid)) |->
      (l_valid && r_valid && l_data == r_data));

  // R11: strobes follow a completing bit-clock rise by one cycle
  p_after_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (l_valid || r_valid) |-> ($past(bit_rise) && $past(word_done)));

  // R11: one-cycle strobes
  p_one_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    l_valid |=> !l_valid);

  // R6: short right-justified words are sign-extended
  p_sext_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass_on && mode[1:0] == 2'b10 && l_valid) |->
      ($countones(l_data[W-1:SW-1]) == 0 ||
       $countones(l_data[W-1:SW-1]) == W - SW + 1));
endmodule

bind serial_audio_rx sai_checker #(.W(W), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .bit_rise(bit_rise),
  .word_done(word_done), .l_valid(l_valid), .l_data(l_data),
  .r_valid(r_valid), .r_data(r_data), .bypass_on(bypass_on)
);

// File: tb/sim_serial_audio_rx.sv
module sim_serial_audio_rx;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0, bclk = 1'b0, wclk = 1'b0, sdata = 1'b0;
  logic [3:0]  mode = 4'b0;
  logic        l_valid, r_valid, slow_rolloff, bypass_on;
  logic [23:0] l_data, r_data;

  serial_audio_rx u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .bclk(bclk), .wclk(wclk),
    .sdata(sdata), .l_valid(l_valid), .l_data(l_data), .r_valid(r_valid),
    .r_data(r_data), .slow_rolloff(slow_rolloff), .bypass_on(bypass_on)
  );

  typedef struct {
    bit lv; bit rv; logic [23:0] ld; logic [23:0] rd; string req;
  } exp_t;
  exp_t sb[$];
  int errors = 0, checks = 0;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pop and compare every strobe
  always @(negedge clk) begin
    if (rst_n && (l_valid || r_valid)) begin
      if (sb.size() == 0) begin
        chk(0, "R7/R12 unexpected strobe", {30'd0, l_valid, r_valid}, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk({l_valid, r_valid} == {e.lv, e.rv}, e.req,
            {30'd0, l_valid, r_valid}, {30'd0, e.lv, e.rv});
        if (e.lv) chk(l_data == e.ld, e.req, {8'd0, l_data}, {8'd0, e.ld});
        if (e.rv) chk(r_data == e.rd, e.req, {8'd0, r_data}, {8'd0, e.rd});
      end
    end
  end

  task automatic one_bit(logic lvl, logic d);
    @(negedge clk); bclk = 1'b0; wclk = lvl; sdata = d;
    @(negedge clk);
    @(negedge clk); bclk = 1'b1;
    @(negedge clk);
  endtask

  // drive one word-clock period; cls: 0 lj, 1 i2s, 2 rj16, 3 rj24
  task automatic half(int cls, logic lvl, logic [23:0] w, int nb, logic fill);
    for (int i = 0; i < nb; i++) begin
      int k;
      logic d;
      k = nb - 1 - i;
      case (cls)
        0: d = (i < 24) ? w[23-i] : fill;
        1: d = (i >= 1 && i <= 24) ? w[24-i] : fill;
        2: d = (k < 16) ? w[k] : fill;
        default: d = (k < 24) ? w[k] : fill;
      endcase
      one_bit(lvl, d);
    end
  endtask

  task automatic stream(logic [3:0] m, int n, int nb, logic fill, int seed,
                        string req);
    bit mono, ch, byp, rj, ok, left, lvl;
    int cls;
    logic [23:0] w, v;
    @(negedge clk); rst_n = 1'b0; bclk = 1'b0; wclk = 1'b0; mode = m;
    repeat (3) @(negedge clk);
    chk(!l_valid && !r_valid && l_data == 0 && r_data == 0, "R1 reset state",
        {6'd0, l_valid, r_valid, l_data}, 0);
    mono = m[3]; ch = m[2];
    byp  = !mono && ch && m[1:0] == 2'b11;
    chk(bypass_on == byp, "R2 bypass flag", {31'd0, bypass_on}, {31'd0, byp});
    chk(slow_rolloff == (!mono && ch && !byp), "R3 rolloff flag",
        {31'd0, slow_rolloff}, {31'd0, !mono && ch && !byp});
    rst_n = 1'b1;
    rj  = byp || m[1];
    cls = byp ? 3 : (m[1:0] == 2'b00 ? 1 : (m[1:0] == 2'b01 ? 0 : int'(m[1:0])));
    for (int i = 0; i < n; i++) begin
      lvl = i[0];
      w   = 24'hA5C3E1 ^ (24'(i) * 24'h13579) ^ 24'(seed * 24'h0F1D3);
      ok  = (i >= 1) && (!rj || i <= n - 2);   // R12: first period dropped
      if (byp) ok = ok && lvl;
      left = byp ? 1'b1 : (m[1:0] == 2'b00 ? !lvl : lvl);
      v = (!byp && m[1:0] == 2'b10) ? 24'($signed(w[15:0])) : w;
      if (mono) ok = ok && (left == !ch);
      if (ok) begin
        exp_t e;
        e.lv = mono || byp || left;
        e.rv = mono || byp || !left;
        e.ld = v; e.rd = v; e.req = req;
        sb.push_back(e);
      end
      half(cls, lvl, w, nb, fill);
    end
    repeat (20) @(negedge clk);
    chk(sb.size() == 0, {req, " all words delivered"}, sb.size(), 0);
    sb.delete();
  endtask

  initial begin
    stream(4'b0001, 8, 32, 1'b1, 1, "R4 R7 left-justified");
    stream(4'b0000, 8, 32, 1'b1, 2, "R5 R7 I2S");
    stream(4'b0011, 8, 32, 1'b1, 3, "R6 R7 rj24 R8");
    stream(4'b0010, 8, 24, 1'b1, 4, "R6 rj16 sign extension");
    stream(4'b0101, 6, 26, 1'b0, 5, "R3 R4 slow left-justified");
    stream(4'b1000, 8, 32, 1'b0, 6, "R9 mono left I2S");
    stream(4'b1111, 8, 30, 1'b1, 7, "R9 mono right rj24");
    stream(4'b0111, 10, 24, 1'b1, 8, "R10 bypass");
    stream(4'b0110, 6, 28, 1'b0, 9, "R3 R6 slow rj16 R11");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%h expected=%h", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule